// File: doc/BRIEF.md
# Block-Mode Word DMA Channel

This block is one DMA channel that copies 32-bit words between a word-addressed system memory port and a peripheral data stream. Software programs three registers (a byte start address, a block descriptor and a channel control word) through a simple write port. Writing a control word with its start bit set launches the transfer.

The transfer length is the upper half of the block descriptor multiplied by its lower half. The channel aligns the start address to a word boundary and clips the length so that no access goes past the end of memory. It then streams the words in ascending address order. When it finishes, it writes the advanced address back into the start-address register, drops the busy bit and raises a one-cycle completion interrupt.

The memory port and both peripheral directions use valid/ready rules. A memory access takes place in a cycle where `mem_valid` and `mem_ready` are both high. The channel raises `mem_valid` only when the peripheral side can take part in that same cycle. Toward the peripheral, `per_tx_valid` is high only while memory is ready, so a word crosses both sides in one cycle. From the peripheral, `per_rx_ready` is high only while memory is ready. Either side holding its ready or valid low stalls the channel without losing or repeating a word.

Top module: `dma_block_channel`

## Requirements
- R1: The number of words moved equals `block[31:16] * block[15:0]`, a 32-bit product. The words move in ascending address order.
- R2: The two low bits of the start address are ignored. Every memory access is word aligned, and the address steps by 4 per word.
- R3: Control value 0x01000201 copies memory to the peripheral. Each word read at `mem_addr` appears on `per_tx_data`.
- R4: Control value 0x01000200 copies the peripheral to memory. Each word accepted on `per_rx_data` is written at `mem_addr` with `mem_we` high.
- R5: Control bit 24 is the busy bit. It reads 1 from the cycle after launch until completion, then 0. While it is 0, no memory or peripheral handshake is offered.
- R6: On completion, the start-address register holds the aligned start address plus 4 times the number of words moved.
- R7: A control write with bit 24 set and any other value moves no data. It stores the value with bit 24 cleared, and `irq` is high in the next cycle.
- R8: `irq` is a single-cycle pulse that follows completion only while busy was still set. A control write with bit 24 clear during a transfer stops it, clears busy, stores the address reached and raises no interrupt.
- R9: With memory of `MEM_WORDS` words, the transfer is clipped to the words between the aligned start and the end of memory.
- R10: A length of zero, including one clipped to zero, completes without any memory access, and the interrupt follows within two cycles.
- R11: A word moves only in a cycle where both memory and the peripheral side are ready. While stalled, the address holds.
- R12: Writes to the start-address and block registers are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 start address, 1 block, 2 control |
| cfg_wdata | input | 32 | Register write data |
| reg_base | output | 32 | Start-address register |
| reg_block | output | 32 | Block register |
| reg_ctrl | output | 32 | Control register |
| busy | output | 1 | Control bit 24 |
| irq | output | 1 | Completion interrupt pulse |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| per_tx_valid | output | 1 | Word offered to the peripheral |
| per_tx_data | output | DATA_W | Word toward the peripheral |
| per_tx_ready | input | 1 | Peripheral takes the word |
| per_rx_valid | input | 1 | Peripheral offers a word |
| per_rx_data | input | DATA_W | Word from the peripheral |
| per_rx_ready | output | 1 | Channel takes the peripheral word |

## Verification
A miscounted word counter shows up within one transfer. Words go missing or extra words appear in the peripheral stream or in memory, and the address written back is off by a multiple of 4 at the completion cycle. A busy flag that disagrees with the engine shows at once, either as a handshake offered while busy reads 0 or as an interrupt that never arrives. Stalls are checked on every cycle. The address must hold while memory is not ready, and a word must never cross one side without the other.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned  BUSY_POS        = 24;
  localparam logic [31:0]  BUSY_MASK       = 32'h0100_0000;
  localparam logic [31:0]  CODE_TO_PERIPH  = 32'h0100_0201;
  localparam logic [31:0]  CODE_FROM_PERIPH = 32'h0100_0200;

  typedef enum logic [1:0] {
    CFG_BASE  = 2'd0,
    CFG_BLOCK = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/dma_chan_span.sv
module dma_chan_span #(
  parameter int unsigned MEM_WORDS = 4096
) (
  input  logic [31:0] base_q,
  input  logic [31:0] blk_q,
  output logic [31:0] start_addr,
  output logic [31:0] words
);
  localparam logic [31:0] LIMIT = 32'(MEM_WORDS);

  logic [31:0] product;
  logic [31:0] start_word;
  logic [31:0] avail;

  always_comb begin
    product    = {16'd0, blk_q[31:16]} * {16'd0, blk_q[15:0]};
    start_word = {2'b00, base_q[31:2]};
    avail      = (start_word >= LIMIT) ? 32'd0 : (LIMIT - start_word);
    words      = (product < avail) ? product : avail;
    start_addr = {base_q[31:2], 2'b00};
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        fin_valid,
  input  logic [31:0] fin_addr,
  output logic [31:0] base_q,
  output logic [31:0] blk_q,
  output logic [31:0] ctrl_q,
  output logic        launch,
  output logic        reject,
  output logic        cancel
);
  logic busy_now;
  logic wr_ctrl;
  logic go_bit;
  logic known;

  always_comb begin
    busy_now = ctrl_q[BUSY_POS];
    wr_ctrl  = cfg_we && (cfg_sel_e'(cfg_sel) == CFG_CTRL);
    go_bit   = cfg_wdata[BUSY_POS];
    known    = (cfg_wdata == CODE_TO_PERIPH) || (cfg_wdata == CODE_FROM_PERIPH);
    launch   = wr_ctrl && !busy_now && go_bit && known;
    reject   = wr_ctrl && !busy_now && go_bit && !known;
    cancel   = wr_ctrl && busy_now && !go_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (cfg_we && !busy_now) begin
        case (cfg_sel_e'(cfg_sel))
          CFG_BASE:  base_q <= cfg_wdata;
          CFG_BLOCK: blk_q  <= cfg_wdata;
          CFG_CTRL:  ctrl_q <= reject ? (cfg_wdata & ~BUSY_MASK) : cfg_wdata;
          default:   ;
        endcase
      end
      if (cancel) ctrl_q <= ctrl_q & ~BUSY_MASK;
      if (fin_valid) begin
        base_q <= fin_addr;
        ctrl_q <= ctrl_q & ~BUSY_MASK;
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_to_per,
  input  logic [31:0]       launch_addr,
  input  logic [31:0]       launch_words,
  input  logic              cancel,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_tx_ready,
  input  logic              per_rx_valid,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              running,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              per_tx_valid,
  output logic [DATA_W-1:0] per_tx_data,
  output logic              per_rx_ready,
  output logic              fin_valid,
  output logic [31:0]       fin_addr,
  output logic              fin_irq
);
  logic        to_per_q;
  logic [31:0] remain_q;
  logic [31:0] cur_q;
  logic        pending;
  logic        side_ok;
  logic        move;

  always_comb begin
    pending      = running && (remain_q != 32'd0) && !cancel;
    side_ok      = to_per_q ? per_tx_ready : per_rx_valid;
    mem_valid    = pending && side_ok;
    move         = mem_valid && mem_ready;
    per_tx_valid = pending && to_per_q && mem_ready;
    per_rx_ready = pending && !to_per_q && mem_ready;
    mem_we       = running && !to_per_q;
    mem_addr     = cur_q;
    mem_wdata    = per_rx_data;
    per_tx_data  = mem_rdata;
    fin_valid    = running && ((remain_q == 32'd0) || cancel);
    fin_addr     = cur_q;
    fin_irq      = !cancel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      to_per_q <= 1'b0;
      remain_q <= '0;
      cur_q    <= '0;
    end else if (launch) begin
      running  <= 1'b1;
      to_per_q <= launch_to_per;
      remain_q <= launch_words;
      cur_q    <= launch_addr;
    end else if (fin_valid) begin
      running  <= 1'b0;
    end else if (move) begin
      remain_q <= remain_q - 32'd1;
      cur_q    <= cur_q + 32'd4;
    end
  end
endmodule

// File: rtl/dma_block_channel.sv
module dma_block_channel
  import dma_chan_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MEM_WORDS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       reg_base,
  output logic [31:0]       reg_block,
  output logic [31:0]       reg_ctrl,
  output logic              busy,
  output logic              irq,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              per_tx_valid,
  output logic [DATA_W-1:0] per_tx_data,
  input  logic              per_tx_ready,
  input  logic              per_rx_valid,
  input  logic [DATA_W-1:0] per_rx_data,
  output logic              per_rx_ready
);
  logic        launch, reject, cancel;
  logic        fin_valid, fin_irq;
  logic [31:0] fin_addr;
  logic [31:0] span_addr, span_words;
  logic        eng_running;
  logic        irq_q;

  dma_chan_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fin_valid(fin_valid), .fin_addr(fin_addr),
    .base_q(reg_base), .blk_q(reg_block), .ctrl_q(reg_ctrl),
    .launch(launch), .reject(reject), .cancel(cancel)
  );

  dma_chan_span #(.MEM_WORDS(MEM_WORDS)) u_span (
    .base_q(reg_base), .blk_q(reg_block),
    .start_addr(span_addr), .words(span_words)
  );

  dma_chan_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .launch_to_per(cfg_wdata[0]),
    .launch_addr(span_addr), .launch_words(span_words),
    .cancel(cancel),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .per_tx_ready(per_tx_ready), .per_rx_valid(per_rx_valid), .per_rx_data(per_rx_data),
    .running(eng_running),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .per_tx_valid(per_tx_valid), .per_tx_data(per_tx_data), .per_rx_ready(per_rx_ready),
    .fin_valid(fin_valid), .fin_addr(fin_addr), .fin_irq(fin_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (fin_valid && fin_irq) || reject;
  end

  assign irq  = irq_q;
  assign busy = reg_ctrl[BUSY_POS];
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int unsigned MEM_WORDS = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        running,
  input logic        irq,
  input logic        reject,
  input logic        cancel,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        per_tx_valid,
  input logic        per_tx_ready,
  input logic        per_rx_ready
);
  localparam logic [31:0] MEM_BYTES = 32'(MEM_WORDS * 4);

  a_r5_busy_tracks_engine: assert property (@(posedge clk) disable iff (!rst_n)
    busy == running);
  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !per_tx_valid && !per_rx_ready));
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));
  a_r9_inside_memory: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr < MEM_BYTES));
  a_r11_step_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (mem_addr == $past(mem_addr) + 32'd4));
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_addr == $past(mem_addr)));
  a_r11_tx_both_sides: assert property (@(posedge clk) disable iff (!rst_n)
    (per_tx_valid && per_tx_ready) |-> (mem_valid && mem_ready));
  a_r7_reject_raises: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (irq && !busy));
  a_r8_cancel_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> (!irq && !busy));
  a_r8_irq_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

bind dma_block_channel dma_chan_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .running(eng_running), .irq(irq),
  .reject(reject), .cancel(cancel), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .per_tx_valid(per_tx_valid), .per_tx_ready(per_tx_ready),
  .per_rx_ready(per_rx_ready)
);

// File: tb/tb_dma_block_channel.sv
`timescale 1ns/1ps
module tb_dma_block_channel;
  localparam int unsigned MW = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] reg_base, reg_block, reg_ctrl;
  logic        busy, irq;
  logic        mem_valid, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        per_tx_valid, per_tx_ready = 1'b1;
  logic [31:0] per_tx_data;
  logic        per_rx_valid = 1'b0, per_rx_ready;
  logic [31:0] per_rx_data = '0;

  int vectors = 0;
  int miscompares = 0;
  int tx_fires = 0;
  int cyc = 0;
  bit stall_on = 1'b0;
  bit rx_fire = 1'b0;
  bit finished = 1'b0;
  logic [31:0] mem [0:MW-1];
  logic [31:0] exp_q[$];
  logic [31:0] rx_q[$];

  always #2 clk = ~clk;

  dma_block_channel #(.DATA_W(32), .MEM_WORDS(MW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .reg_base(reg_base), .reg_block(reg_block), .reg_ctrl(reg_ctrl), .busy(busy), .irq(irq),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .per_tx_valid(per_tx_valid), .per_tx_data(per_tx_data), .per_tx_ready(per_tx_ready),
    .per_rx_valid(per_rx_valid), .per_rx_data(per_rx_data), .per_rx_ready(per_rx_ready)
  );

  assign mem_rdata = mem[mem_addr[9:2]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // memory model: writes land at the edge of the handshake
  always @(posedge clk)
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

  // stimulus side: ready patterns and peripheral source, driven after the edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rx_fire && rx_q.size() > 0) void'(rx_q.pop_front());
    mem_ready    = !stall_on || (cyc % 3 != 1);
    per_tx_ready = !stall_on || (cyc % 4 != 2);
    per_rx_valid = (rx_q.size() > 0) && (!stall_on || (cyc % 5 != 0));
    per_rx_data  = (rx_q.size() > 0) ? rx_q[0] : 32'd0;
  end

  // monitor: scoreboard for the peripheral stream, sampled mid-cycle
  always @(negedge clk) begin
    rx_fire = per_rx_valid && per_rx_ready;
    if (per_tx_valid && per_tx_ready) begin
      tx_fires++;
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected word", per_tx_data, 32'd0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(per_tx_data == e, "R1/R3 stream word", per_tx_data, e);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    report();
  end

  initial begin
    bit seen;
    int f0;
    for (int i = 0; i < MW; i++) mem[i] = 32'hA000_0000 + 32'(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && irq == 1'b0, "R5 reset idle", {30'd0, busy, irq}, 32'd0);
    chk(reg_base == 32'd0 && reg_ctrl == 32'd0, "R5 reset regs", reg_ctrl, 32'd0);

    // memory to peripheral, unaligned start 0x43, 3x4 words, with stalls
    stall_on = 1'b1;
    for (int i = 16; i < 28; i++) exp_q.push_back(32'hA000_0000 + 32'(i));
    f0 = tx_fires;
    cfg_write(2'd0, 32'h0000_0043);
    cfg_write(2'd1, 32'h0003_0004);
    cfg_write(2'd2, 32'h0100_0201);
    @(negedge clk);
    chk(busy == 1'b1, "R5 busy after launch", {31'd0, busy}, 32'd1);
    wait_irq(200, seen);
    chk(seen, "R8 irq after transfer", {31'd0, seen}, 32'd1);
    chk(busy == 1'b0, "R5 busy cleared", {31'd0, busy}, 32'd0);
    chk(reg_base == 32'h70, "R2/R6 address writeback", reg_base, 32'h70);
    chk(tx_fires - f0 == 12, "R1/R11 word count", 32'(tx_fires - f0), 32'd12);
    @(negedge clk);
    chk(irq == 1'b0, "R8 single-cycle irq", {31'd0, irq}, 32'd0);

    // peripheral to memory, 5x2 words at 0x200
    for (int i = 0; i < 10; i++) rx_q.push_back(32'h5500_0000 + 32'(i));
    cfg_write(2'd0, 32'h0000_0200);
    cfg_write(2'd1, 32'h0005_0002);
    cfg_write(2'd2, 32'h0100_0200);
    wait_irq(200, seen);
    chk(seen, "R4 irq after receive", {31'd0, seen}, 32'd1);
    chk(reg_base == 32'h228, "R6 address after receive", reg_base, 32'h228);
    for (int i = 0; i < 10; i++)
      chk(mem[128 + i] == 32'h5500_0000 + 32'(i), "R4 memory word", mem[128 + i], 32'h5500_0000 + 32'(i));

    // unsupported control value
    f0 = tx_fires;
    cfg_write(2'd2, 32'h0100_0202);
    @(negedge clk);
    chk(irq == 1'b1 && busy == 1'b0, "R7 reject irq", {30'd0, irq, busy}, 32'd2);
    chk(reg_ctrl == 32'h0000_0202, "R7 stored without busy", reg_ctrl, 32'h0000_0202);
    chk(tx_fires == f0 && reg_base == 32'h228, "R7 no data moved", reg_base, 32'h228);

    // zero length
    cfg_write(2'd1, 32'h0000_0007);
    cfg_write(2'd2, 32'h0100_0201);
    wait_irq(2, seen);
    chk(seen, "R10 zero length irq", {31'd0, seen}, 32'd1);
    chk(reg_base == 32'h228 && tx_fires == f0, "R10 no access", reg_base, 32'h228);

    // clipped at end of memory: word 250, 16 asked, 6 available
    for (int i = 250; i < 256; i++) exp_q.push_back(mem[i]);
    f0 = tx_fires;
    cfg_write(2'd0, 32'd1000);
    cfg_write(2'd1, 32'h0001_0010);
    cfg_write(2'd2, 32'h0100_0201);
    wait_irq(200, seen);
    chk(seen, "R9 irq after clip", {31'd0, seen}, 32'd1);
    chk(tx_fires - f0 == 6, "R9 clipped count", 32'(tx_fires - f0), 32'd6);
    chk(reg_base == 32'd1024, "R9 address at end", reg_base, 32'd1024);

    // cancel in mid-flight, with writes to base/block ignored while busy
    for (int i = 0; i < 5; i++) rx_q.push_back(32'h7700_0000 + 32'(i));
    cfg_write(2'd0, 32'h0000_0300);
    cfg_write(2'd1, 32'h0014_0001);
    cfg_write(2'd2, 32'h0100_0200);
    repeat (40) @(posedge clk);
    cfg_write(2'd0, 32'h0000_0999);
    cfg_write(2'd1, 32'h0000_0001);
    @(negedge clk);
    chk(reg_base == 32'h300 && reg_block == 32'h0014_0001, "R12 writes ignored", reg_base, 32'h300);
    chk(busy == 1'b1, "R11 stalled still busy", {31'd0, busy}, 32'd1);
    cfg_write(2'd2, 32'h0000_0200);
    @(negedge clk);
    chk(busy == 1'b0, "R8 cancel clears busy", {31'd0, busy}, 32'd0);
    chk(reg_base == 32'h314, "R8 cancel address", reg_base, 32'h314);
    chk(mem[196] == 32'h7700_0004, "R4 last word before cancel", mem[196], 32'h7700_0004);
    wait_irq(10, seen);
    chk(!seen, "R8 no irq on cancel", {31'd0, seen}, 32'd0);
    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
    report();
  end
endmodule